// File: doc/BRIEF.md
# Codec Sample Capture Controller

This block sits between the deserialiser of an incoming serial codec link and two receive FIFOs, one for the audio channel and one for the telecom channel. On each received frame it decides, separately for each channel, whether that frame's data word is a fresh sample that should be written into the channel's FIFO.

Two sampling modes are supported, chosen by a single mode input. In the flag-driven mode a channel trusts the frame's data-valid flag and captures every frame in which the flag is set. In the paced mode the flag is used only once, to line up with the codec on the first valid frame after enable. From then on a local sample-rate down-counter, loaded from a per-channel divisor, decides when a new sample is due. A codec that leaves its valid flag stuck high therefore produces one FIFO entry per sample period rather than one per frame. A full FIFO blocks the write and raises a sticky per-channel overrun flag.

Top module: `codec_capture_ctrl`

## Requirements
- R1: With `mode` = 0 and `enable` = 1, every cycle with `frame_stb` = 1 and a channel's valid flag = 1 (and its FIFO not full) produces, in the next cycle, a one-cycle write strobe on that channel with the data word present at the strobe.
- R2: No write strobe is produced for a channel in the cycle after a cycle without `frame_stb`. In flag-driven mode a frame whose valid flag is 0 writes nothing.
- R3: With `mode` = 1, after enable a channel is unaligned. Frames without its valid flag write nothing. The first frame with the flag set is captured, and the channel becomes aligned.
- R4: With `mode` = 1 and the channel aligned, its valid flag has no effect. A frame writes only when a capture is pending.
- R5: The aligning capture loads the channel's counter with its divisor D. The counter then counts down one per clock and times out when it sits at 0, reloading D, so the time-outs are D+1 clocks apart. A time-out sets a pending capture. The pending capture is consumed by the first `frame_stb` in a later cycle. A frame in the same cycle as the time-out does not consume it.
- R6: Any number of time-outs before a frame arrives leave at most one pending capture, so that frame yields exactly one write.
- R7: The audio and telecom channels are independent, each with its own flag, divisor, counter, pending state, FIFO-full input and overrun flag.
- R8: While `enable` = 0 no writes occur and both channels return to the unaligned state. After a new enable they wait for a valid flag again.
- R9: A capture that meets its FIFO-full input produces no write strobe and sets the channel's overrun output in the next cycle. The overrun output stays set until a cycle with its clear input = 1 and no new overrun. A new overrun in the same cycle as the clear keeps it set.
- R10: A synchronous active-high `rst` clears all write strobes and overrun outputs, and leaves both channels unaligned with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Capture enable; low resets alignment |
| mode | input | 1 | 0 = flag-driven, 1 = counter-paced |
| frame_stb | input | 1 | One-cycle pulse when a frame has been received |
| audio_valid | input | 1 | Audio data-valid flag of the current frame |
| audio_data | input | DATA_W | Audio data word of the current frame |
| audio_div | input | DIV_W | Audio sample-rate divisor D |
| audio_full | input | 1 | Audio receive FIFO is full |
| audio_ovr_clr | input | 1 | Write-one-to-clear pulse for audio overrun |
| tele_valid | input | 1 | Telecom data-valid flag of the current frame |
| tele_data | input | DATA_W | Telecom data word of the current frame |
| tele_div | input | DIV_W | Telecom sample-rate divisor D |
| tele_full | input | 1 | Telecom receive FIFO is full |
| tele_ovr_clr | input | 1 | Write-one-to-clear pulse for telecom overrun |
| audio_wr | output | 1 | Audio FIFO write strobe |
| audio_wdata | output | DATA_W | Audio FIFO write data, valid with the strobe |
| audio_ovr | output | 1 | Sticky audio overrun flag |
| tele_wr | output | 1 | Telecom FIFO write strobe |
| tele_wdata | output | DATA_W | Telecom FIFO write data, valid with the strobe |
| tele_ovr | output | 1 | Sticky telecom overrun flag |

## Verification
The bench holds the valid flag stuck high in paced mode. A design that kept trusting the flag would write on every frame instead of once per period. It lets several time-outs pass before a single frame, which catches a design that queues captures and writes twice. It also places frames right next to time-outs, which exposes an off-by-one in the counter period or a same-cycle consume. Further cases cover dropping enable between alignments, where a design that kept its alignment would capture before any valid flag, and overruns raised in the same cycle as a clear pulse, where a design that lets the clear win would lose the flag.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_DIV_W  = 10;
    localparam int unsigned NUM_CHAN   = 2;

    typedef enum logic {
        MODE_FLAG  = 1'b0,
        MODE_PACED = 1'b1
    } smode_e;

    typedef enum logic {
        ALIGN_WAIT  = 1'b0,
        ALIGN_PACED = 1'b1
    } align_e;

    typedef struct packed {
        logic frame;
        logic valid;
        logic full;
        logic ovr_clr;
    } chan_evt_t;

    // decides whether the frame in this cycle is a sample to capture
    function automatic logic capture_due(smode_e m, align_e a, logic pend, logic valid);
        if (m == MODE_FLAG)        return valid;
        else if (a == ALIGN_WAIT)  return valid;
        else                       return pend;
    endfunction

    // pending capture: set by time-out, consumed by a later frame
    function automatic logic next_pending(logic pend, logic timeout, logic frame);
        return timeout | (pend & ~frame);
    endfunction

endpackage

// File: rtl/cap_rate_timer.sv
module cap_rate_timer
    import cap_pkg::*;
#(
    parameter int unsigned DIV_W = DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             timeout
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign timeout = run & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= div;
        end else if (run) begin
            cnt_q <= at_zero ? div : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DIV_W  = DEF_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  smode_e            mode,
    input  chan_evt_t         evt,
    input  logic [DATA_W-1:0] data,
    input  logic [DIV_W-1:0]  div,
    output logic              wr,
    output logic [DATA_W-1:0] wdata,
    output logic              ovr
);

    align_e align_q;
    logic   pend_q;
    logic   paced;
    logic   capture;
    logic   align_load;
    logic   timer_run;
    logic   timeout;

    assign paced      = enable & (mode == MODE_PACED);
    assign capture    = enable & evt.frame & capture_due(mode, align_q, pend_q, evt.valid);
    assign align_load = paced & (align_q == ALIGN_WAIT) & evt.frame & evt.valid;
    assign timer_run  = paced & (align_q == ALIGN_PACED);

    cap_rate_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (align_load),
        .run     (timer_run),
        .div     (div),
        .timeout (timeout)
    );

    // alignment and pending state
    always_ff @(posedge clk) begin
        if (rst || !paced) begin
            align_q <= ALIGN_WAIT;
            pend_q  <= 1'b0;
        end else if (align_q == ALIGN_WAIT) begin
            pend_q <= 1'b0;
            if (align_load) align_q <= ALIGN_PACED;
        end else begin
            pend_q <= next_pending(pend_q, timeout, evt.frame);
        end
    end

    // FIFO-side outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            wr    <= 1'b0;
            wdata <= '0;
            ovr   <= 1'b0;
        end else begin
            wr  <= capture & ~evt.full;
            ovr <= (ovr & ~evt.ovr_clr) | (capture & evt.full);
            if (capture && !evt.full) wdata <= data;
        end
    end

endmodule

// File: rtl/codec_capture_ctrl.sv
module codec_capture_ctrl
    import cap_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DIV_W  = DEF_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              mode,
    input  logic              frame_stb,
    input  logic              audio_valid,
    input  logic [DATA_W-1:0] audio_data,
    input  logic [DIV_W-1:0]  audio_div,
    input  logic              audio_full,
    input  logic              audio_ovr_clr,
    input  logic              tele_valid,
    input  logic [DATA_W-1:0] tele_data,
    input  logic [DIV_W-1:0]  tele_div,
    input  logic              tele_full,
    input  logic              tele_ovr_clr,
    output logic              audio_wr,
    output logic [DATA_W-1:0] audio_wdata,
    output logic              audio_ovr,
    output logic              tele_wr,
    output logic [DATA_W-1:0] tele_wdata,
    output logic              tele_ovr
);

    localparam int unsigned NCH = NUM_CHAN;

    chan_evt_t         evt_a   [NCH];
    logic [DATA_W-1:0] data_a  [NCH];
    logic [DIV_W-1:0]  div_a   [NCH];
    logic              wr_a    [NCH];
    logic [DATA_W-1:0] wdata_a [NCH];
    logic              ovr_a   [NCH];
    smode_e            mode_e;

    assign mode_e = smode_e'(mode);

    // channel 0: audio, channel 1: telecom
    assign evt_a[0]  = '{frame: frame_stb, valid: audio_valid, full: audio_full, ovr_clr: audio_ovr_clr};
    assign evt_a[1]  = '{frame: frame_stb, valid: tele_valid,  full: tele_full,  ovr_clr: tele_ovr_clr};
    assign data_a[0] = audio_data;
    assign data_a[1] = tele_data;
    assign div_a[0]  = audio_div;
    assign div_a[1]  = tele_div;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cap_channel #(
            .DATA_W (DATA_W),
            .DIV_W  (DIV_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .enable (enable),
            .mode   (mode_e),
            .evt    (evt_a[c]),
            .data   (data_a[c]),
            .div    (div_a[c]),
            .wr     (wr_a[c]),
            .wdata  (wdata_a[c]),
            .ovr    (ovr_a[c])
        );
    end

    assign audio_wr    = wr_a[0];
    assign audio_wdata = wdata_a[0];
    assign audio_ovr   = ovr_a[0];
    assign tele_wr     = wr_a[1];
    assign tele_wdata  = wdata_a[1];
    assign tele_ovr    = ovr_a[1];

endmodule

// File: rtl/codec_capture_chk.sv
module codec_capture_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              mode,
    input logic              frame_stb,
    input logic              audio_valid,
    input logic [DATA_W-1:0] audio_data,
    input logic              audio_full,
    input logic              audio_ovr_clr,
    input logic              tele_valid,
    input logic [DATA_W-1:0] tele_data,
    input logic              tele_full,
    input logic              tele_ovr_clr,
    input logic              audio_wr,
    input logic [DATA_W-1:0] audio_wdata,
    input logic              audio_ovr,
    input logic              tele_wr,
    input logic [DATA_W-1:0] tele_wdata,
    input logic              tele_ovr
);

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!audio_wr && !tele_wr && !audio_ovr && !tele_ovr));

    a_r1_audio_flag_capture: assert property (@(posedge clk) disable iff (rst)
        (!mode && enable && frame_stb && audio_valid && !audio_full)
        |=> (audio_wr && audio_wdata == $past(audio_data)));

    a_r1_tele_flag_capture: assert property (@(posedge clk) disable iff (rst)
        (!mode && enable && frame_stb && tele_valid && !tele_full)
        |=> (tele_wr && tele_wdata == $past(tele_data)));

    a_r2_no_frame_no_write: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> (!audio_wr && !tele_wr));

    a_r2_flag_clear_no_write: assert property (@(posedge clk) disable iff (rst)
        (!mode && !audio_valid) |=> !audio_wr);

    a_r8_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!audio_wr && !tele_wr));

    a_r9_audio_full_blocks: assert property (@(posedge clk) disable iff (rst)
        audio_full |=> !audio_wr);

    a_r9_tele_full_blocks: assert property (@(posedge clk) disable iff (rst)
        tele_full |=> !tele_wr);

    a_r9_audio_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (audio_ovr && !audio_ovr_clr) |=> audio_ovr);

    a_r9_tele_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (tele_ovr && !tele_ovr_clr) |=> tele_ovr);

    a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
        ($rose(audio_ovr) |-> $past(audio_full)));

endmodule

bind codec_capture_ctrl codec_capture_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .mode          (mode),
    .frame_stb     (frame_stb),
    .audio_valid   (audio_valid),
    .audio_data    (audio_data),
    .audio_full    (audio_full),
    .audio_ovr_clr (audio_ovr_clr),
    .tele_valid    (tele_valid),
    .tele_data     (tele_data),
    .tele_full     (tele_full),
    .tele_ovr_clr  (tele_ovr_clr),
    .audio_wr      (audio_wr),
    .audio_wdata   (audio_wdata),
    .audio_ovr     (audio_ovr),
    .tele_wr       (tele_wr),
    .tele_wdata    (tele_wdata),
    .tele_ovr      (tele_ovr)
);

// File: tb/tb_codec_capture_ctrl.sv
module tb_codec_capture_ctrl;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic mode = 1'b0;
    logic frame_stb = 1'b0;
    logic vl [2];
    logic [DATA_W-1:0] dat [2];
    logic [DIV_W-1:0]  dv  [2];
    logic full [2];
    logic clr  [2];

    logic              audio_wr, tele_wr, audio_ovr, tele_ovr;
    logic [DATA_W-1:0] audio_wdata, tele_wdata;
    logic              o_wr  [2];
    logic              o_ovr [2];
    logic [DATA_W-1:0] o_dat [2];

    // reference model state
    logic              m_al  [2];
    logic              m_pd  [2];
    int                m_cnt [2];
    logic              e_wr  [2];
    logic              e_ovr [2];
    logic [DATA_W-1:0] e_dat [2];
    int                wr_seen [2];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    codec_capture_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .mode(mode), .frame_stb(frame_stb),
        .audio_valid(vl[0]), .audio_data(dat[0]), .audio_div(dv[0]),
        .audio_full(full[0]), .audio_ovr_clr(clr[0]),
        .tele_valid(vl[1]), .tele_data(dat[1]), .tele_div(dv[1]),
        .tele_full(full[1]), .tele_ovr_clr(clr[1]),
        .audio_wr(audio_wr), .audio_wdata(audio_wdata), .audio_ovr(audio_ovr),
        .tele_wr(tele_wr), .tele_wdata(tele_wdata), .tele_ovr(tele_ovr)
    );

    assign o_wr[0]  = audio_wr;    assign o_wr[1]  = tele_wr;
    assign o_ovr[0] = audio_ovr;   assign o_ovr[1] = tele_ovr;
    assign o_dat[0] = audio_wdata; assign o_dat[1] = tele_wdata;

    function automatic logic exp_capture(int c);
        if (!enable || !frame_stb) return 1'b0;
        if (!mode) return vl[c];
        return m_al[c] ? m_pd[c] : vl[c];
    endfunction

    // advance the model by one clock using the inputs now applied
    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            logic cap;
            logic to;
            if (rst) begin
                e_wr[c] = 0; e_ovr[c] = 0; m_al[c] = 0; m_pd[c] = 0; m_cnt[c] = 0;
            end else begin
                cap = exp_capture(c);
                e_wr[c]  = cap & ~full[c];
                if (cap && !full[c]) e_dat[c] = dat[c];
                e_ovr[c] = (e_ovr[c] & ~clr[c]) | (cap & full[c]);
                if (!enable || !mode) begin
                    m_al[c] = 0; m_pd[c] = 0;
                end else if (!m_al[c]) begin
                    m_pd[c] = 0;
                    if (frame_stb && vl[c]) begin m_al[c] = 1; m_cnt[c] = int'(dv[c]); end
                end else begin
                    to = (m_cnt[c] == 0);
                    m_pd[c] = to | (m_pd[c] & ~frame_stb);
                    m_cnt[c] = to ? int'(dv[c]) : m_cnt[c] - 1;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        for (int c = 0; c < 2; c++) begin
            checks++;
            if (o_wr[c] !== e_wr[c]) begin
                errors++;
                $display("FAIL %s ch%0d wr: actual %b expected %b", tag, c, o_wr[c], e_wr[c]);
            end
            if (e_wr[c]) begin
                checks++;
                if (o_dat[c] !== e_dat[c]) begin
                    errors++;
                    $display("FAIL %s ch%0d wdata: actual %h expected %h", tag, c, o_dat[c], e_dat[c]);
                end
            end
            checks++;
            if (o_ovr[c] !== e_ovr[c]) begin
                errors++;
                $display("FAIL %s ch%0d ovr: actual %b expected %b", tag, c, o_ovr[c], e_ovr[c]);
            end
            if (o_wr[c] === 1'b1) wr_seen[c]++;
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic quiet();
        frame_stb = 0;
        for (int c = 0; c < 2; c++) begin
            vl[c] = 0; full[c] = 0; clr[c] = 0; dat[c] = DATA_W'($urandom);
        end
    endtask

    task automatic rand_run(input string tag, input int n, input int stb_pct,
                            input int vl_pct, input int full_pct, input int clr_pct);
        for (int i = 0; i < n; i++) begin
            frame_stb = ($urandom % 100) < stb_pct;
            for (int c = 0; c < 2; c++) begin
                vl[c]   = ($urandom % 100) < vl_pct;
                full[c] = ($urandom % 100) < full_pct;
                clr[c]  = ($urandom % 100) < clr_pct;
                dat[c]  = DATA_W'($urandom);
            end
            tick(tag);
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            quiet();
            tick(tag);
        end
    endtask

    task automatic expect_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int c = 0; c < 2; c++) begin
            e_dat[c] = '0; e_wr[c] = 0; e_ovr[c] = 0; wr_seen[c] = 0;
            dv[c] = DIV_W'(3 + 2 * c);
        end
        quiet();
        @(negedge clk);
        // R10: reset state
        rst = 1;
        tick("R10");
        tick("R10");
        rst = 0;
        idle("R10", 2);

        // R1: flag-driven mode, random traffic, FIFOs never full
        enable = 1; mode = 0;
        rand_run("R1", 400, 60, 50, 0, 0);
        // R2: frames with clear flags, and flags without frames
        rand_run("R2", 200, 50, 0, 0, 0);
        rand_run("R2", 200, 0, 90, 0, 0);

        // R3: paced mode, unaligned frames without flag, then one with flag
        mode = 1;
        for (int i = 0; i < 10; i++) begin quiet(); frame_stb = 1; tick("R3"); end
        quiet(); frame_stb = 1; vl[0] = 1; vl[1] = 1; tick("R3");
        idle("R3", 2);
        expect_eq("R3 audio aligning write", wr_seen[0] >= 1 ? 1 : 0, 1);

        // R4: flag stuck high, frames often
        rand_run("R4", 600, 70, 100, 0, 0);
        // R5: divisors changed, frames every cycle and sparse
        dv[0] = 1; dv[1] = 7;
        rand_run("R5", 400, 100, 30, 0, 0);
        dv[0] = 0; dv[1] = 2;
        rand_run("R5", 400, 25, 60, 0, 0);

        // R6: many time-outs with no frame, then a single frame
        dv[0] = 2; dv[1] = 4;
        idle("R6", 40);
        wr_seen[0] = 0; wr_seen[1] = 0;
        quiet(); frame_stb = 1; vl[0] = 1; vl[1] = 1; tick("R6");
        idle("R6", 1);
        expect_eq("R6 audio writes", wr_seen[0], 1);
        expect_eq("R6 tele writes", wr_seen[1], 1);

        // R7: unequal divisors, independent flags
        dv[0] = 1; dv[1] = 9;
        rand_run("R7", 500, 40, 50, 0, 0);
        mode = 0;
        rand_run("R7", 300, 60, 50, 0, 0);

        // R8: disabled, then re-enabled must wait for a flag again
        mode = 1;
        enable = 0;
        rand_run("R8", 100, 70, 80, 0, 0);
        enable = 1;
        wr_seen[0] = 0; wr_seen[1] = 0;
        for (int i = 0; i < 30; i++) begin quiet(); frame_stb = 1; tick("R8"); end
        idle("R8", 1);
        expect_eq("R8 audio writes before flag", wr_seen[0], 0);
        expect_eq("R8 tele writes before flag", wr_seen[1], 0);
        rand_run("R8", 200, 50, 50, 0, 0);

        // R9: full FIFOs, clear pulses, sticky overrun
        mode = 0;
        quiet(); frame_stb = 1; vl[0] = 1; full[0] = 1; tick("R9");
        idle("R9", 5);
        expect_eq("R9 audio overrun held", int'(audio_ovr), 1);
        expect_eq("R9 tele untouched", int'(tele_ovr), 0);
        quiet(); frame_stb = 1; vl[0] = 1; full[0] = 1; clr[0] = 1; tick("R9");
        expect_eq("R9 set beats clear", int'(audio_ovr), 1);
        quiet(); clr[0] = 1; tick("R9");
        expect_eq("R9 cleared", int'(audio_ovr), 0);
        rand_run("R9", 500, 60, 60, 30, 10);
        mode = 1;
        rand_run("R9", 500, 60, 60, 30, 10);

        // R10: reset in the middle of activity
        rst = 1;
        rand_run("R10", 1, 60, 60, 30, 0);
        rst = 0;
        idle("R10", 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule